// File: doc/BRIEF.md
# Underflow Down-Counter Timer Channel

This block is a single timer channel. It counts down a 32-bit value by one on each prescaler tick it is allowed to see. A tick that arrives while the count is already zero is an underflow, and the channel treats it as an expiry. A loaded value N therefore expires on tick N+1. On expiry the channel can raise a one-clock interrupt pulse and latch a sticky pending flag. It then either reloads from its reload word and keeps running, or parks at zero.

Software-facing state is reached through three write strobes that share one data bus: the counter word, the reload word and the control word. The three words are always visible on separate read buses. Address decoding, the prescaler, chaining between channels and debug freezing all live outside this block.

Control word bits are fixed:
- bit 0 is run-enable.
- bit 1 is auto-reload.
- bit 2 is load. It acts only on the write and reads as 0.
- bit 3 is interrupt enable.
- bit 4 is pending. Writing 1 to it clears it.
- bits 31:5 always read 0.

Sequencing is a two-state machine, ST_IDLE and ST_RUN.
- T_START: any counter or control write whose resulting enable is 1 moves to, or stays in, ST_RUN.
- T_HALT: any such write whose resulting enable is 0 moves to ST_IDLE.
- T_WRAP: an expiry with auto-reload set stays in ST_RUN.
- T_EXPIRE_STOP: an expiry without auto-reload moves to ST_IDLE.
- Without a write or an expiry, the state holds.

Top module: `tmr_chan_top`

## Requirements
- R1: After reset the counter, reload and control read buses are all zero, the interrupt output is low and the channel is idle.
- R2: The counter decreases by exactly one on a clock where the tick input is high and the channel is running. With no tick, or when idle, the counter holds its value.
- R3: A tick that arrives while running with a count of zero is an expiry, so a load of N expires on tick N+1. If interrupt enable (bit 3) is set, the interrupt output is high for the one clock that follows the expiry edge. If bit 3 is clear, the output stays low.
- R4: An expiry with interrupt enable set makes control bit 4 (pending) read 1. The flag stays at 1 across later ticks and expiries until it is cleared.
- R5: A control write with bit 4 = 1 clears pending. A control write with bit 4 = 0 leaves pending as it was.
- R6: An expiry with auto-reload (bit 1) set copies the reload word into the counter, and counting continues. An expiry without bit 1 leaves the counter at zero and the channel idle, and no further expiries follow.
- R7: A control write with load (bit 2) set copies the reload word into the counter. The channel then runs only if bit 0 of the same write is 1. Bit 2 always reads back as 0.
- R8: A counter write puts the data value into the counter. The channel then runs only if enable is set.
- R9: Control bits 31:5 always read as 0, whatever was written.
- R10: A counter or control write takes precedence over a tick in the same clock. That tick is discarded and causes neither a decrement nor an expiry.
- R11: A control write with bit 0 = 0 and bit 2 = 0 stops counting, and the counter keeps its current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick, one clock wide |
| wr_cnt_i | input | 1 | Counter word write strobe |
| wr_rld_i | input | 1 | Reload word write strobe |
| wr_cfg_i | input | 1 | Control word write strobe |
| wdata_i | input | 32 | Write data shared by the three strobes |
| rd_cnt_o | output | 32 | Live counter value |
| rd_rld_o | output | 32 | Reload word |
| rd_cfg_o | output | 32 | Control word readback |
| irq_o | output | 1 | Interrupt pulse, one clock per enabled expiry |

## Verification
Every result is registered once. Counter, reload and control readback, and the interrupt output, all change at the first rising edge after the strobe or tick that causes them. The bench drives inputs on the falling edge and holds each strobe or tick for exactly one clock. It samples at the next falling edge, which is half a period after the edge where the result is due. For expiry timing, the bench applies ticks one at a time and checks the interrupt after each one. This confirms the pulse follows tick N+1 and no other tick, and a sample one clock later confirms the pulse has dropped.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
    // Control word bit positions (software-visible, fixed by behaviour)
    localparam int unsigned CB_EN   = 0;
    localparam int unsigned CB_AUTO = 1;
    localparam int unsigned CB_LOAD = 2;
    localparam int unsigned CB_IE   = 3;
    localparam int unsigned CB_PEND = 4;
    localparam int unsigned CB_USED = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
    import tmr_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_cfg,
    input  logic [CB_USED-1:0] wbits,
    input  logic               expire,
    output logic               en_q,
    output logic               auto_q,
    output logic               ie_q,
    output logic [CB_USED-1:0] cfg_rd
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            auto_q <= 1'b0;
            ie_q   <= 1'b0;
        end else if (wr_cfg) begin
            en_q   <= wbits[CB_EN];
            auto_q <= wbits[CB_AUTO];
            ie_q   <= wbits[CB_IE];
        end
    end

    // Pending: write-one clears, otherwise an enabled expiry sets it.
    // A control write blocks expiry in the same cycle, so no collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (wr_cfg && wbits[CB_PEND]) begin
            pend_q <= 1'b0;
        end else if (expire && ie_q) begin
            pend_q <= 1'b1;
        end
    end

    always_comb begin
        cfg_rd          = '0;
        cfg_rd[CB_EN]   = en_q;
        cfg_rd[CB_AUTO] = auto_q;
        cfg_rd[CB_IE]   = ie_q;
        cfg_rd[CB_PEND] = pend_q;
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_chan_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_cfg,
    input  logic [DW-1:0] wdata,
    input  logic          w_en,
    input  logic          w_load,
    input  logic [DW-1:0] reload_val,
    input  logic          en_q,
    input  logic          auto_q,
    output logic [DW-1:0] count,
    output logic          running,
    output logic          expire
);
    run_state_e state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic any_wr;
    logic en_after;

    assign any_wr   = wr_cnt | wr_cfg;
    assign en_after = wr_cfg ? w_en : en_q;
    assign running  = (state_q == ST_RUN);
    assign expire   = running && tick && !any_wr && (cnt_q == '0);
    assign count    = cnt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_START / T_HALT on writes, T_WRAP / T_EXPIRE_STOP on expiry
    always_comb begin
        state_d = state_q;
        if (any_wr) begin
            state_d = en_after ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN: begin
                    if (expire) begin
                        state_d = auto_q ? ST_RUN : ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wdata;
        end else if (wr_cfg && w_load) begin
            cnt_q <= reload_val;
        end else if (expire && auto_q) begin
            cnt_q <= reload_val;
        end else if (running && tick && !wr_cfg && (cnt_q != '0)) begin
            cnt_q <= cnt_q - DW'(1);
        end
    end
endmodule

// File: rtl/tmr_irq_pulse.sv
module tmr_irq_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic ie_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= expire & ie_q;
        end
    end
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
    import tmr_chan_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_cnt_i,
    input  logic          wr_rld_i,
    input  logic          wr_cfg_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rd_cnt_o,
    output logic [DW-1:0] rd_rld_o,
    output logic [DW-1:0] rd_cfg_o,
    output logic          irq_o
);
    localparam int unsigned PAD_W = DW - CB_USED;

    logic [DW-1:0]      rld_q;
    logic               en_q, auto_q, ie_q;
    logic [CB_USED-1:0] cfg_bits;
    logic               running;
    logic               expire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else if (wr_rld_i) begin
            rld_q <= wdata_i;
        end
    end

    tmr_cfg_reg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (wr_cfg_i),
        .wbits  (wdata_i[CB_USED-1:0]),
        .expire (expire),
        .en_q   (en_q),
        .auto_q (auto_q),
        .ie_q   (ie_q),
        .cfg_rd (cfg_bits)
    );

    tmr_count_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_i),
        .wr_cnt     (wr_cnt_i),
        .wr_cfg     (wr_cfg_i),
        .wdata      (wdata_i),
        .w_en       (wdata_i[CB_EN]),
        .w_load     (wdata_i[CB_LOAD]),
        .reload_val (rld_q),
        .en_q       (en_q),
        .auto_q     (auto_q),
        .count      (rd_cnt_o),
        .running    (running),
        .expire     (expire)
    );

    tmr_irq_pulse u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .ie_q   (ie_q),
        .irq    (irq_o)
    );

    assign rd_rld_o = rld_q;
    assign rd_cfg_o = {{PAD_W{1'b0}}, cfg_bits};
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          wr_cnt_i,
    input logic          wr_cfg_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] rd_cnt_o,
    input logic [DW-1:0] rd_rld_o,
    input logic [DW-1:0] rd_cfg_o,
    input logic          irq_o,
    input logic          run_i
);
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_cnt_i && !wr_cfg_i) |=> $stable(rd_cnt_o)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_cnt_i && !wr_cfg_i) |=> $stable(rd_cnt_o)); // R11

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !wr_cnt_i && !wr_cfg_i && (rd_cnt_o != '0))
        |=> (rd_cnt_o == $past(rd_cnt_o) - DW'(1))); // R2

    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(rd_cfg_o[3])); // R3

    AST_IRQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> rd_cfg_o[4]); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cfg_o[4] && !wr_cfg_i) |=> rd_cfg_o[4]); // R4

    AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg_i && wdata_i[4]) |=> !rd_cfg_o[4]); // R5

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg_i && wdata_i[2] && !wr_cnt_i) |=> (rd_cnt_o == $past(rd_rld_o))); // R7

    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> (rd_cnt_o == $past(wdata_i))); // R8

    AST_CFG_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cfg_o[DW-1:5] == '0) && !rd_cfg_o[2]); // R9
endmodule

bind tmr_chan_top tmr_chan_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .wr_cnt_i (wr_cnt_i),
    .wr_cfg_i (wr_cfg_i),
    .wdata_i  (wdata_i),
    .rd_cnt_o (rd_cnt_o),
    .rd_rld_o (rd_rld_o),
    .rd_cfg_o (rd_cfg_o),
    .irq_o    (irq_o),
    .run_i    (running)
);

// File: tb/sim_tmr_chan_top.sv
module sim_tmr_chan_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          wr_cnt_i = 1'b0;
    logic          wr_rld_i = 1'b0;
    logic          wr_cfg_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rd_cnt_o, rd_rld_o, rd_cfg_o;
    logic          irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_chan_top #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_cnt_i(wr_cnt_i), .wr_rld_i(wr_rld_i), .wr_cfg_i(wr_cfg_i),
        .wdata_i(wdata_i), .rd_cnt_o(rd_cnt_o), .rd_rld_o(rd_rld_o),
        .rd_cfg_o(rd_cfg_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One-clock strobe; inputs change on falling edges, results sampled one falling edge later
    task automatic strobe(input bit cnt, input bit rld, input bit cfg, input logic [DW-1:0] v, input bit tk);
        wr_cnt_i = cnt; wr_rld_i = rld; wr_cfg_i = cfg; wdata_i = v; tick_i = tk;
        @(negedge clk);
        wr_cnt_i = 0; wr_rld_i = 0; wr_cfg_i = 0; wdata_i = '0; tick_i = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 cnt", rd_cnt_o, 0);
        check("R1 rld", rd_rld_o, 0);
        check("R1 cfg", rd_cfg_o, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
        strobe(0, 0, 0, '0, 1);
        check("R1 idle after tick", rd_cnt_o, 0);
    endtask

    task automatic t_decrement;
        strobe(0, 1, 0, 32'd5, 0);
        strobe(0, 0, 1, 32'h5, 0);
        check("R7 load copies", rd_cnt_o, 5);
        check("R7 load reads 0", rd_cfg_o, 32'h1);
        idle(3);
        check("R2 hold no tick", rd_cnt_o, 5);
        strobe(0, 0, 0, '0, 1);
        strobe(0, 0, 0, '0, 1);
        check("R2 two ticks", rd_cnt_o, 3);
    endtask

    task automatic t_expiry_stop;
        int irq_seen;
        strobe(0, 1, 0, 32'd3, 0);
        strobe(0, 0, 1, 32'h0D, 0);
        irq_seen = 0;
        for (int k = 1; k <= 4; k++) begin
            strobe(0, 0, 0, '0, 1);
            if (irq_o) irq_seen++;
            if (k < 4) check("R3 no early irq", {31'b0, irq_o}, 0);
        end
        check("R3 irq after tick N+1", {31'b0, irq_o}, 1);
        idle(1);
        check("R3 pulse one clock", {31'b0, irq_o}, 0);
        check("R4 pending set", rd_cfg_o, 32'h19);
        for (int k = 0; k < 3; k++) strobe(0, 0, 0, '0, 1);
        check("R6 stopped at zero", rd_cnt_o, 0);
        check("R6 no further irq", {31'b0, irq_o}, 0);
        check("R4 pending sticky", rd_cfg_o, 32'h19);
        check("R3 single pulse", irq_seen, 1);
    endtask

    task automatic t_w1c;
        strobe(0, 0, 1, 32'h08, 0);
        check("R5 write 0 keeps pending", rd_cfg_o, 32'h18);
        strobe(0, 0, 1, 32'h10, 0);
        check("R5 write 1 clears", rd_cfg_o, 32'h0);
    endtask

    task automatic t_restart;
        int irq_seen;
        strobe(0, 1, 0, 32'd2, 0);
        strobe(0, 0, 1, 32'h0F, 0);
        check("R7 cfg readback", rd_cfg_o, 32'h0B);
        irq_seen = 0;
        for (int k = 1; k <= 6; k++) begin
            strobe(0, 0, 0, '0, 1);
            if (irq_o) irq_seen++;
            if (k == 3) check("R6 reloaded after wrap", rd_cnt_o, 2);
        end
        check("R6 two expiries", irq_seen, 2);
        check("R6 reloaded again", rd_cnt_o, 2);
        strobe(0, 0, 1, 32'h10, 0);
    endtask

    task automatic t_no_ie;
        int irq_seen;
        strobe(0, 1, 0, 32'd1, 0);
        strobe(0, 0, 1, 32'h07, 0);
        irq_seen = 0;
        for (int k = 0; k < 2; k++) begin
            strobe(0, 0, 0, '0, 1);
            if (irq_o) irq_seen++;
        end
        check("R3 no irq without ie", irq_seen, 0);
        check("R3 no pending without ie", rd_cfg_o, 32'h03);
        check("R6 wrapped count", rd_cnt_o, 1);
    endtask

    task automatic t_load_disabled;
        strobe(0, 1, 0, 32'd9, 0);
        strobe(0, 0, 1, 32'h04, 0);
        check("R7 load while disabled", rd_cnt_o, 9);
        strobe(0, 0, 0, '0, 1);
        check("R7 no run when disabled", rd_cnt_o, 9);
    endtask

    task automatic t_counter_write;
        strobe(1, 0, 0, 32'd7, 0);
        check("R8 counter write", rd_cnt_o, 7);
        strobe(0, 0, 0, '0, 1);
        check("R8 idle when disabled", rd_cnt_o, 7);
        strobe(0, 0, 1, 32'h01, 0);
        check("R8 enable keeps count", rd_cnt_o, 7);
        strobe(0, 0, 0, '0, 1);
        check("R8 runs when enabled", rd_cnt_o, 6);
        strobe(1, 0, 0, 32'd20, 0);
        strobe(0, 0, 0, '0, 1);
        check("R8 write while running", rd_cnt_o, 19);
    endtask

    task automatic t_stop;
        strobe(0, 0, 1, 32'h00, 0);
        strobe(0, 0, 0, '0, 1);
        strobe(0, 0, 0, '0, 1);
        check("R11 stop holds", rd_cnt_o, 19);
    endtask

    task automatic t_collision;
        strobe(0, 0, 1, 32'h01, 1);
        check("R10 cfg write beats tick", rd_cnt_o, 19);
        strobe(1, 0, 0, 32'd4, 1);
        check("R10 cnt write beats tick", rd_cnt_o, 4);
        strobe(1, 0, 0, 32'd0, 0);
        strobe(0, 0, 1, 32'h09, 1);
        check("R10 no expiry on write", {31'b0, irq_o}, 0);
        check("R10 no pending on write", rd_cfg_o, 32'h09);
    endtask

    task automatic t_reserved;
        strobe(0, 0, 1, 32'hFFFF_FFEF, 0);
        check("R9 reserved read 0", rd_cfg_o, 32'h0B);
        check("R7 load on full write", rd_cnt_o, 9);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decrement();
        t_expiry_stop();
        t_w1c();
        t_restart();
        t_no_ie();
        t_load_disabled();
        t_counter_write();
        t_stop();
        t_collision();
        t_reserved();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule